// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block moves a group of registers between a register file and word memory, one word per cycle. A single start request carries an 8-bit list for registers 0 to 7, an extra-register flag, a direction, a base address and a mode. In stack mode the base is the stack pointer. A store then works as a push, and the extra flag adds the link register (index 14). A load works as a pop, and the extra flag adds the program counter (index 15). In general mode the base is an ordinary pointer, and the block runs an increment-after block load or store over registers 0 to 7 only.

Every sequence walks memory in ascending word order, taking the lowest-numbered listed register first and the extra register last. The block reads register values through a read port that returns data in the same cycle, and writes loaded values through a write port. It waits on a ready handshake for each word. When the sequence ends it reports the updated base value, plus a branch target if the program counter was popped.

Top module: `lsm_seq`

## Requirements
- R1: The number of words transferred equals the number of set bits in `reg_list`, plus one when both `stack_mode` and `extra_reg` are 1.
- R2: A stack store (push) starts at the address (base − 4·count) with bits 1:0 cleared. It stores listed registers in ascending index order at ascending word addresses. The link register (index 14) is stored last, at the highest address, and its value is read from the register file at read index 14.
- R3: A stack load (pop) starts at the base with bits 1:0 cleared. It loads listed registers in ascending order from ascending word addresses, and loads the program counter last.
- R4: On completion of a push, `base_we` is 1 and `base_out` equals base − 4·count. On completion of a pop, `base_we` is 1 and `base_out` equals base + 4·count. Neither value is aligned.
- R5: A popped program-counter word is never written to the register file. It appears on `branch_target` with bit 0 cleared, and `branch_valid` pulses together with `done`.
- R6: Every memory request has `mem_addr` bits 1:0 equal to zero.
- R7: In general mode, transfers start at the base with bits 1:0 cleared and step up by 4. `extra_reg` has no effect.
- R8: In general mode, completion gives `base_we` = 1 with `base_out` = base + 4·count, unless bit `base_idx` of `reg_list` is set, in which case `base_we` stays 0.
- R9: `dir_load` = 1 selects loads: each accepted word is written to the register file at the register's index, from `mem_rdata`, with `mem_we` = 0. `dir_load` = 0 selects stores: `mem_we` = 1, and `mem_wdata` carries the register's value.
- R10: A start with an empty transfer count raises `done` in the next cycle. It makes no memory request and leaves `base_we` at 0.
- R11: `done` is a one-cycle pulse in the cycle after the last word is accepted, and `busy` is 0 at that point. A `start` while `busy` is 1 is ignored.
- R12: While `mem_ready` is 0, the request, its address and its direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| dir_load | input | 1 | 1 = load/pop, 0 = store/push |
| stack_mode | input | 1 | 1 = stack pointer base, 0 = general base |
| reg_list | input | 8 | Register list for registers 0 to 7 |
| extra_reg | input | 1 | Adds link register (push) or program counter (pop) in stack mode |
| base_addr | input | 32 | Base address / stack pointer value |
| base_idx | input | 3 | Register index that holds the general base |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts the current word |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (same cycle) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| base_we | output | 1 | Updated base is valid to write back (with `done`) |
| base_out | output | 32 | Updated base value |
| branch_valid | output | 1 | Program counter was popped (with `done`) |
| branch_target | output | 32 | Popped program counter with bit 0 cleared |

## Verification
The bench targets the following cases:
- An unaligned base. A design that forgot the alignment would put the low address bits on the bus, or would align the written-back base when it should not.
- A push of the link register alone and a pop of the program counter alone. A design with the wrong ordering or placement would put the extra register at the lowest address or write the program counter into the register file.
- An odd popped program counter, which exposes a missing bit-0 clear.
- A general-mode load whose base register is in its own list. A wrong design would still write back.
- A general-mode request with the extra flag set. A wrong design would add a ninth word.
- An empty list, random ready stalls, and a start pulsed in mid-sequence. These would expose a stuck `done`, addresses that move during a stall, or a second sequence started while busy.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lsm_state_e;

    // register-file indices of the two special registers
    localparam logic [3:0] LINK_IDX = 4'd14;
    localparam logic [3:0] PC_IDX   = 4'd15;
endpackage

// File: rtl/lsm_plan.sv
module lsm_plan #(
    parameter int LIST_W     = 8,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4,
    localparam int CW        = $clog2(LIST_W + 2),
    localparam int IW        = $clog2(LIST_W),
    localparam int SH        = $clog2(WORD_BYTES)
) (
    input  logic [LIST_W-1:0] list_i,
    input  logic              extra_i,
    input  logic              load_i,
    input  logic              stack_i,
    input  logic [AW-1:0]     base_i,
    input  logic [IW-1:0]     base_idx_i,
    output logic [CW-1:0]     count_o,
    output logic [AW-1:0]     first_addr_o,
    output logic [AW-1:0]     next_base_o,
    output logic              wb_en_o
);
    logic [CW-1:0] pop_cnt;
    logic [AW-1:0] span;
    logic [AW-1:0] align_mask;

    always_comb begin
        pop_cnt = '0;
        for (int i = 0; i < LIST_W; i++) begin
            pop_cnt = pop_cnt + CW'(list_i[i]);
        end
    end

    assign count_o    = pop_cnt + CW'(stack_i & extra_i);
    assign span       = AW'(count_o) << SH;
    assign align_mask = ~AW'(WORD_BYTES - 1);

    always_comb begin
        if (stack_i && !load_i) begin
            next_base_o  = base_i - span;
            first_addr_o = (base_i - span) & align_mask;
        end else begin
            next_base_o  = base_i + span;
            first_addr_o = base_i & align_mask;
        end
    end

    assign wb_en_o = stack_i ? 1'b1 : !list_i[base_idx_i];
endmodule

// File: rtl/lsm_pick.sv
module lsm_pick #(
    parameter int LIST_W = 8,
    localparam int IW    = $clog2(LIST_W)
) (
    input  logic [LIST_W-1:0] mask_i,
    output logic              any_o,
    output logic [IW-1:0]     idx_o,
    output logic [LIST_W-1:0] rest_o
);
    assign any_o  = |mask_i;
    assign rest_o = mask_i & (mask_i - LIST_W'(1));

    always_comb begin
        idx_o = '0;
        for (int i = LIST_W - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
    parameter int LIST_W     = 8,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4,
    localparam int CW        = $clog2(LIST_W + 2),
    localparam int IW        = $clog2(LIST_W),
    localparam int RIW       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_load,
    input  logic              stack_mode,
    input  logic [LIST_W-1:0] reg_list,
    input  logic              extra_reg,
    input  logic [AW-1:0]     base_addr,
    input  logic [IW-1:0]     base_idx,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ready,
    output logic [RIW-1:0]    rf_raddr,
    input  logic [DW-1:0]     rf_rdata,
    output logic              rf_we,
    output logic [RIW-1:0]    rf_waddr,
    output logic [DW-1:0]     rf_wdata,
    output logic              busy,
    output logic              done,
    output logic              base_we,
    output logic [AW-1:0]     base_out,
    output logic              branch_valid,
    output logic [AW-1:0]     branch_target
);
    import lsm_pkg::*;

    typedef struct packed {
        lsm_state_e        state;
        logic [LIST_W-1:0] mask;
        logic              extra;
        logic              load;
        logic [AW-1:0]     addr;
        logic [AW-1:0]     nbase;
        logic              wb;
        logic              done;
        logic              base_we;
        logic [AW-1:0]     base_out;
        logic              br_v;
        logic [AW-1:0]     br_t;
    } seq_t;

    seq_t s_d, s_q;

    logic [CW-1:0]     plan_count;
    logic [AW-1:0]     plan_first;
    logic [AW-1:0]     plan_nbase;
    logic              plan_wb;
    logic              pick_any;
    logic [IW-1:0]     pick_idx;
    logic [LIST_W-1:0] pick_rest;
    logic              running;
    logic              cur_extra;
    logic              cur_last;
    logic [RIW-1:0]    cur_reg;

    lsm_plan #(
        .LIST_W(LIST_W), .AW(AW), .WORD_BYTES(WORD_BYTES)
    ) i_plan (
        .list_i      (reg_list),
        .extra_i     (extra_reg),
        .load_i      (dir_load),
        .stack_i     (stack_mode),
        .base_i      (base_addr),
        .base_idx_i  (base_idx),
        .count_o     (plan_count),
        .first_addr_o(plan_first),
        .next_base_o (plan_nbase),
        .wb_en_o     (plan_wb)
    );

    lsm_pick #(.LIST_W(LIST_W)) i_pick (
        .mask_i(s_q.mask),
        .any_o (pick_any),
        .idx_o (pick_idx),
        .rest_o(pick_rest)
    );

    assign running   = (s_q.state == ST_RUN);
    assign cur_extra = !pick_any;
    assign cur_last  = cur_extra || ((pick_rest == '0) && !s_q.extra);
    assign cur_reg   = pick_any ? {{(RIW-IW){1'b0}}, pick_idx}
                                : (s_q.load ? PC_IDX : LINK_IDX);

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.base_we = 1'b0;
        s_d.br_v    = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (plan_count == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.state = ST_RUN;
                        s_d.mask  = reg_list;
                        s_d.extra = stack_mode & extra_reg;
                        s_d.load  = dir_load;
                        s_d.addr  = plan_first;
                        s_d.nbase = plan_nbase;
                        s_d.wb    = plan_wb;
                    end
                end
            end
            ST_RUN: begin
                if (mem_ready) begin
                    if (pick_any) s_d.mask  = pick_rest;
                    else          s_d.extra = 1'b0;
                    s_d.addr = s_q.addr + AW'(WORD_BYTES);
                    if (s_q.load && cur_extra) begin
                        s_d.br_v = 1'b1;
                        s_d.br_t = mem_rdata & ~AW'(1);
                    end
                    if (cur_last) begin
                        s_d.state    = ST_IDLE;
                        s_d.done     = 1'b1;
                        s_d.base_we  = s_q.wb;
                        s_d.base_out = s_q.nbase;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_req       = running;
    assign mem_we        = running && !s_q.load;
    assign mem_addr      = s_q.addr;
    assign mem_wdata     = rf_rdata;
    assign rf_raddr      = cur_reg;
    assign rf_we         = running && s_q.load && mem_ready && pick_any;
    assign rf_waddr      = cur_reg;
    assign rf_wdata      = mem_rdata;
    assign busy          = running;
    assign done          = s_q.done;
    assign base_we       = s_q.base_we;
    assign base_out      = s_q.base_out;
    assign branch_valid  = s_q.br_v;
    assign branch_target = s_q.br_t;

    // R6
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2
    ascend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + AW'(WORD_BYTES))));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    branch_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> (done && !branch_target[0]));

    // R9
    rf_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (mem_req && mem_ready && !mem_we && (rf_waddr != PC_IDX)));

    // R10
    empty_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (reg_list == '0) && !(stack_mode && extra_reg))
        |=> (done && !busy && !base_we));
endmodule

// File: tb/test_lsm_seq.sv
`timescale 1ns/1ps
module test_lsm_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_load = 1'b0;
    logic        stack_mode = 1'b0;
    logic [7:0]  reg_list = '0;
    logic        extra_reg = 1'b0;
    logic [31:0] base_addr = '0;
    logic [2:0]  base_idx = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we, busy, done, base_we, branch_valid;
    logic [31:0] base_out, branch_target;

    logic [31:0] mem_m [64];
    logic [31:0] regs_m [16];
    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lsm_seq i_lsm_seq (
        .clk, .rst_n, .start, .dir_load, .stack_mode, .reg_list, .extra_reg,
        .base_addr, .base_idx, .mem_req, .mem_we, .mem_addr, .mem_wdata,
        .mem_rdata, .mem_ready, .rf_raddr, .rf_rdata, .rf_we, .rf_waddr,
        .rf_wdata, .busy, .done, .base_we, .base_out, .branch_valid,
        .branch_target
    );

    assign mem_rdata = mem_m[mem_addr[7:2]];
    assign rf_rdata  = regs_m[rf_raddr];

    always @(posedge clk) begin
        if (mem_req && mem_ready && mem_we) mem_m[mem_addr[7:2]] <= mem_wdata;
        if (rf_we) regs_m[rf_waddr] <= rf_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input bit ld, input bit stk, input logic [7:0] lst,
                          input bit ext, input logic [31:0] base,
                          input logic [2:0] bidx, input bit rnd_rdy, input bit poke);
        int seq [10];
        int n = 0;
        logic [31:0] first, exp_base, exp_br, ea, expd;
        bit exp_wb, got_br;
        for (int i = 0; i < 8; i++) if (lst[i]) begin seq[n] = i; n++; end
        if (stk && ext) begin seq[n] = ld ? 15 : 14; n++; end
        if (stk && !ld) begin
            exp_base = base - 32'(4 * n);
            first = exp_base & ~32'h3;
        end else begin
            exp_base = base + 32'(4 * n);
            first = base & ~32'h3;
        end
        exp_wb = stk ? 1'b1 : !lst[bidx];
        exp_br = '0;
        got_br = 0;
        @(negedge clk);
        dir_load = ld; stack_mode = stk; reg_list = lst; extra_reg = ext;
        base_addr = base; base_idx = bidx; start = 1'b1; mem_ready = 1'b0;
        if (n == 0) begin
            @(negedge clk); start = 1'b0; #1;
            chk(done === 1'b1, "R10", "done after empty start", 32'(done), 1);
            chk(mem_req === 1'b0 && busy === 1'b0, "R10", "no request on empty", 32'(mem_req), 0);
            chk(base_we === 1'b0, "R10", "no base write on empty", 32'(base_we), 0);
            @(negedge clk); #1;
            chk(done === 1'b0, "R11", "done is a pulse", 32'(done), 0);
            return;
        end
        for (int k = 0; k < n; k++) begin
            int guard = 0;
            bit acc = 0;
            while (!acc) begin
                @(negedge clk);
                mem_ready = rnd_rdy ? ($urandom % 4 != 0) : 1'b1;
                start = (poke && k == 1);
                if (start) begin reg_list = 8'hFF; base_addr = base + 32'h40; end
                #1;
                acc = mem_req && mem_ready;
                guard++;
                if (guard > 100) begin
                    chk(0, "R1", "transfer stalled", 32'(k), 32'(n));
                    return;
                end
                if (!acc) chk(mem_req === 1'b1 && done === 1'b0, "R12", "request held", 32'(mem_req), 1);
            end
            ea = first + 32'(4 * k);
            chk(mem_addr === ea, stk ? (ld ? "R3" : "R2") : "R7", "word address", mem_addr, ea);
            chk(mem_addr[1:0] === 2'b00, "R6", "alignment", 32'(mem_addr[1:0]), 0);
            chk(mem_we === !ld, "R9", "direction", 32'(mem_we), 32'(!ld));
            if (!ld) begin
                expd = regs_m[seq[k]];
                chk(mem_wdata === expd, "R2", "store data", mem_wdata, expd);
            end else if (seq[k] == 15) begin
                exp_br = mem_m[ea[7:2]] & ~32'h1;
                got_br = 1;
                chk(rf_we === 1'b0, "R5", "pc not written to rf", 32'(rf_we), 0);
            end else begin
                expd = mem_m[ea[7:2]];
                chk(rf_we === 1'b1 && rf_waddr === 4'(seq[k]), "R3", "load target", 32'(rf_waddr), 32'(seq[k]));
                chk(rf_wdata === expd, "R9", "load data", rf_wdata, expd);
            end
        end
        @(negedge clk);
        mem_ready = 1'b0; start = 1'b0; #1;
        chk(done === 1'b1 && busy === 1'b0, "R11", "done after last word", 32'(done), 1);
        chk(base_we === exp_wb, stk ? "R4" : "R8", "base writeback enable", 32'(base_we), 32'(exp_wb));
        if (exp_wb) chk(base_out === exp_base, stk ? "R4" : "R8", "new base", base_out, exp_base);
        chk(branch_valid === got_br, "R5", "branch flag", 32'(branch_valid), 32'(got_br));
        if (got_br) chk(branch_target === exp_br, "R5", "branch target", branch_target, exp_br);
        @(negedge clk); #1;
        chk(done === 1'b0 && busy === 1'b0 && mem_req === 1'b0, "R11", "idle after done, no restart", 32'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) mem_m[i] = $urandom;
        for (int i = 0; i < 16; i++) regs_m[i] = 32'h5A00_0000 + 32'(i * 32'h0101);
        repeat (3) @(negedge clk);
        #1;
        chk(busy === 1'b0 && mem_req === 1'b0 && done === 1'b0, "R11", "reset state", 32'(busy), 0);
        rst_n = 1'b1;
        // R10: empty in both modes
        run_op(1'b0, 1'b0, 8'h00, 1'b0, 32'h2000_0081, 3'd0, 1'b0, 1'b0);
        run_op(1'b1, 1'b1, 8'h00, 1'b0, 32'h2000_0090, 3'd0, 1'b0, 1'b0);
        // R2: push link register only, unaligned base
        run_op(1'b0, 1'b1, 8'h00, 1'b1, 32'h2000_0092, 3'd0, 1'b0, 1'b0);
        // R5: pop program counter only, odd word in memory
        mem_m[6'h24] = 32'h0800_1235;
        run_op(1'b1, 1'b1, 8'h00, 1'b1, 32'h2000_0090, 3'd0, 1'b0, 1'b0);
        // R1 R4: full push then pop with extra
        run_op(1'b0, 1'b1, 8'hFF, 1'b1, 32'h2000_00A0, 3'd0, 1'b1, 1'b0);
        run_op(1'b1, 1'b1, 8'hFF, 1'b1, 32'h2000_007C, 3'd0, 1'b1, 1'b0);
        // R8: general load with base register in list
        run_op(1'b1, 1'b0, 8'h26, 1'b0, 32'h2000_0083, 3'd5, 1'b0, 1'b0);
        // R7: general store with extra set (ignored)
        run_op(1'b0, 1'b0, 8'h81, 1'b1, 32'h2000_0088, 3'd2, 1'b0, 1'b0);
        // R11: start pulsed while busy
        run_op(1'b0, 1'b1, 8'h0A, 1'b1, 32'h2000_0094, 3'd0, 1'b1, 1'b1);
        for (int t = 0; t < 300; t++) begin
            logic [31:0] b = 32'h2000_0080 + 32'(($urandom % 8) * 4) + 32'($urandom % 4);
            logic [7:0] l = ($urandom % 8 == 0) ? 8'h00 : 8'($urandom);
            run_op(1'($urandom), 1'($urandom), l, 1'($urandom), b,
                   3'($urandom), 1'b1, ($urandom % 10 == 0));
        end
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule